// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker

This block computes parity over a data word built from a chain of nine-input parity stages. The chain is the cascade itself: the first stage reduces nine data bits, and every later stage reduces eight fresh data bits together with the odd-count flag handed on by the stage before it. With `STAGES` stages the word is `8*STAGES+1` bits wide, so the default of two stages covers 17 bits.

A mode input selects between two roles for one shared parity line. In transmit mode (`chk_mode` low) the block drives the line. The line is high when the word holds an even number of ones. In check mode (`chk_mode` high) the block releases the line and reads it as the received parity bit. An active-low error output reports a received bit that disagrees with the word. The shared line is modelled as a drive value, a drive enable and a sampled input, and the enclosing logic resolves the wire.

All outputs are registered, so each result appears one clock after the inputs that produced it. A synchronous active-high reset keeps the line released and the error output inactive. This stands in for the requirement that the line stays undriven while power is unstable.

Top module: `par_cascade_unit`

## Requirements
- R1: `parity_o` is 1 when the number of ones in `data_i` is even and 0 when it is odd, outside reset, in either mode.
- R2: `parity_oe` is 1 when `chk_mode` was 0 and 0 when `chk_mode` was 1, outside reset.
- R3: With `chk_mode` 0, `err_n_o` is 1 for every data word and every value on `parity_i`.
- R4: With `chk_mode` 1, an even number of ones in `data_i` and `parity_i` at 0 give `err_n_o` = 0.
- R5: With `chk_mode` 1, an odd number of ones in `data_i` and `parity_i` at 1 give `err_n_o` = 0.
- R6: With `chk_mode` 1, `err_n_o` is 1 whenever `parity_i` equals 1 for an even count or 0 for an odd count.
- R7: While `rst` is 1 at a clock edge, the following values hold in either mode: `parity_oe` = 0, `err_n_o` = 1 and `parity_o` = 1.
- R8: Every bit of `data_i` takes part in the parity. Bits [8:0] feed the first stage, and bits [8k+8:8k+1] feed stage k together with the previous stage's flag. A single one at any position therefore gives an odd count.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. Changing the word on every cycle yields a fresh result on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_mode | input | 1 | 0 = transmit (drive the line), 1 = check (read the line) |
| data_i | input | 8*STAGES+1 | Data word covered by the parity |
| parity_i | input | 1 | Sampled value of the shared parity line |
| parity_o | output | 1 | Value to drive on the line, 1 for an even count of ones |
| parity_oe | output | 1 | Drive enable for the shared line |
| err_n_o | output | 1 | Parity error flag, active low |

## Verification
The assertions assume that `parity_i` carries a defined level whenever `chk_mode` is high. They also assume that no other driver contends with the block while `parity_oe` is high. The bench resolves the line as the block's own value when the enable is high and as the bench's value otherwise. It sets check mode one cycle before it treats the received bit as meaningful, which leaves the enable time to fall. It does not judge the error flag on that transition cycle. On the return to transmit mode the flag is checked at once, because it must stay high whatever the line carries.

// File: rtl/par_cascade_pkg.sv
package par_cascade_pkg;
  localparam int unsigned LANES = 9;

  function automatic int unsigned word_bits(input int unsigned stages);
    return (LANES - 1) * stages + 1;
  endfunction
endpackage

// File: rtl/par_stage.sv
module par_stage #(
  parameter int unsigned LANES = par_cascade_pkg::LANES
) (
  input  logic [LANES-1:0] bits_i,
  output logic             odd_o
);
  always_comb begin
    odd_o = 1'b0;
    for (int unsigned i = 0; i < LANES; i++) begin
      odd_o = odd_o ^ bits_i[i];
    end
  end
endmodule

// File: rtl/par_chain.sv
module par_chain #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned LANES  = par_cascade_pkg::LANES,
  localparam int unsigned WORD_W = par_cascade_pkg::word_bits(STAGES)
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              odd_o
);
  logic [STAGES-1:0] link;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      par_stage #(.LANES(LANES)) i_stage (
        .bits_i (word_i[LANES-1:0]),
        .odd_o  (link[0])
      );
    end else begin : g_tail
      par_stage #(.LANES(LANES)) i_stage (
        .bits_i ({word_i[(LANES-1)*k+LANES-1:(LANES-1)*k+1], link[k-1]}),
        .odd_o  (link[k])
      );
    end
  end

  assign odd_o = link[STAGES-1];
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic chk_i,
  input  logic odd_i,
  input  logic parity_i,
  output logic parity_o,
  output logic parity_oe,
  output logic err_n
);
  logic mismatch;

  assign mismatch = (parity_i == odd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      parity_o  <= 1'b1;
      parity_oe <= 1'b0;
      err_n     <= 1'b1;
    end else begin
      parity_o  <= ~odd_i;
      parity_oe <= ~chk_i;
      err_n     <= chk_i ? ~mismatch : 1'b1;
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) $past(rst) |-> (!parity_oe && err_n)); // R7
  AST_ENABLE_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (parity_oe == !$past(chk_i))); // R2
  AST_NO_ERROR_IN_TX: assert property (@(posedge clk) disable iff (rst) (!err_n) |-> $past(chk_i)); // R3
  AST_MATCH_NO_ERROR: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(chk_i) && ($past(parity_i) != $past(odd_i))) |-> err_n); // R6
  AST_PARITY_HOLDS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $stable(odd_i)) |=> $stable(parity_o)); // R1
endmodule

// File: rtl/par_cascade_unit.sv
module par_cascade_unit #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned WORD_W = par_cascade_pkg::word_bits(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_mode,
  input  logic [WORD_W-1:0] data_i,
  input  logic              parity_i,
  output logic              parity_o,
  output logic              parity_oe,
  output logic              err_n_o
);
  logic word_odd;

  par_chain #(.STAGES(STAGES)) i_chain (
    .word_i (data_i),
    .odd_o  (word_odd)
  );

  par_port_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .chk_i     (chk_mode),
    .odd_i     (word_odd),
    .parity_i  (parity_i),
    .parity_o  (parity_o),
    .parity_oe (parity_oe),
    .err_n     (err_n_o)
  );

  AST_RESET_RELEASES_LINE: assert property (@(posedge clk) $past(rst) |-> (parity_o && !parity_oe)); // R7
endmodule

// File: tb/test_par_cascade_unit.sv
module test_par_cascade_unit;
  localparam int unsigned STAGES = 2;
  localparam int unsigned DW = 8 * STAGES + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chk = 1'b0;
  logic [DW-1:0] data = '0;
  logic          tb_val = 1'b0;
  logic          port_bus;
  logic          parity_o, parity_oe, err_n_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp_par;
    logic  exp_oe;
    logic  exp_err;
    bit    judge_err;
    string tag_par;
    string tag_oe;
    string tag_err;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;

  assign port_bus = parity_oe ? parity_o : tb_val;

  par_cascade_unit #(.STAGES(STAGES)) i_par_cascade_unit (
    .clk       (clk),
    .rst       (rst),
    .chk_mode  (chk),
    .data_i    (data),
    .parity_i  (port_bus),
    .parity_o  (parity_o),
    .parity_oe (parity_oe),
    .err_n_o   (err_n_o)
  );

  task automatic cmp(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      cmp(parity_o, it.exp_par, it.tag_par, "parity_o");
      cmp(parity_oe, it.exp_oe, it.tag_oe, "parity_oe");
      if (it.judge_err) cmp(err_n_o, it.exp_err, it.tag_err, "err_n_o");
    end
  end

  task automatic drive(input logic r, input logic c, input logic [DW-1:0] d, input logic pv,
                       input bit judge, input string tpar, input string terr);
    item_t it;
    int ones;
    logic odd;
    @(negedge clk);
    rst = r; chk = c; data = d; tb_val = pv;
    ones = 0;
    for (int b = 0; b < DW; b++) if (d[b]) ones++;
    odd = (ones % 2) == 1;
    it.exp_par   = r ? 1'b1 : !odd;
    it.exp_oe    = !r && !c;
    it.exp_err   = r ? 1'b1 : (c ? !(pv == odd) : 1'b1);
    it.judge_err = judge;
    it.tag_par   = r ? "R7" : tpar;
    it.tag_oe    = r ? "R7" : "R2";
    it.tag_err   = r ? "R7" : terr;
    sb.push_back(it);
  endtask

  function automatic logic [DW-1:0] mix(input int p);
    logic [DW-1:0] v;
    v = DW'(p) ^ (DW'(p * 37 + 11) << 9);
    return v;
  endfunction

  function automatic string check_tag(input logic [DW-1:0] d, input logic pv);
    if ((($countones(d) % 2) == 0) && !pv) return "R4";
    if ((($countones(d) % 2) == 1) && pv) return "R5";
    return "R6";
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: reset in both modes with arbitrary data
    drive(1'b1, 1'b0, mix(3), 1'b0, 1'b1, "R7", "R7");
    drive(1'b1, 1'b0, mix(5), 1'b1, 1'b1, "R7", "R7");
    drive(1'b1, 1'b1, mix(8), 1'b0, 1'b1, "R7", "R7");
    drive(1'b1, 1'b1, mix(9), 1'b1, 1'b1, "R7", "R7");
    // R1, R3: transmit sweep of all 512 low patterns
    for (int p = 0; p < 512; p++) drive(1'b0, 1'b0, mix(p), 1'b0, 1'b1, "R1", "R3");
    // R9: alternating words every cycle
    for (int p = 0; p < 16; p++) drive(1'b0, 1'b0, (p % 2 == 0) ? DW'(0) : DW'(1), 1'b0, 1'b1, "R9", "R3");
    // switch to check: enable still high this cycle, error not judged
    drive(1'b0, 1'b1, '0, 1'b0, 1'b0, "R1", "R6");
    // R4, R5, R6: check sweep, both line values
    for (int p = 0; p < 512; p++) begin
      for (int v = 0; v < 2; v++) drive(1'b0, 1'b1, mix(p), v[0], 1'b1, "R1", check_tag(mix(p), v[0]));
    end
    // R8: walking one in check mode, matching and mismatching line
    for (int b = 0; b < DW; b++) begin
      drive(1'b0, 1'b1, DW'(1) << b, 1'b0, 1'b1, "R8", "R8");
      drive(1'b0, 1'b1, DW'(1) << b, 1'b1, 1'b1, "R8", "R8");
    end
    // back to transmit: R3 holds even while the line is foreign
    drive(1'b0, 1'b0, mix(77), 1'b1, 1'b1, "R1", "R3");
    // R8: walking one and pairs in transmit
    for (int b = 0; b < DW; b++) drive(1'b0, 1'b0, DW'(1) << b, 1'b0, 1'b1, "R8", "R3");
    for (int b = 1; b < DW; b++) drive(1'b0, 1'b0, (DW'(1) << b) | DW'(1), 1'b1, 1'b1, "R8", "R3");
    drive(1'b0, 1'b0, '1, 1'b0, 1'b1, "R8", "R3");
    // R7: reset mid-run from check mode
    drive(1'b0, 1'b1, mix(4), 1'b0, 1'b0, "R1", "R6");
    drive(1'b0, 1'b1, mix(4), 1'b0, 1'b1, "R1", check_tag(mix(4), 1'b0));
    drive(1'b1, 1'b1, mix(4), 1'b1, 1'b1, "R7", "R7");
    drive(1'b1, 1'b0, mix(6), 1'b0, 1'b1, "R7", "R7");
    drive(1'b0, 1'b0, mix(6), 1'b0, 1'b1, "R1", "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule